// File: doc/BRIEF.md
# Paged Memory Card Address Decoder

This block sits on a paged memory expansion card. It watches the 16-bit CPU address and an active-low memory-enable strobe, and from them produces the card's strobes: a select for the expansion RAM windows, a select for the page-mapper register file, and a combined card select. The combined select also drives the enables of the data bus buffer and the read-data buffer. The register file and the SRAM devices are separate parts. This block supplies their control and address lines.

Software steers the card through eight write-only control bits. It writes them one at a time on a serial control bus at a fixed base address. Bit 0 opens the mapper registers in the 0x4000–0x5FFF window. Bit 1 switches the mapper from pass-through to map mode. In pass-through mode every 4 KB bank uses the page equal to its own bank number. In map mode the page comes from the mapper register file. The block then spreads the effective page over two SRAM chip selects and the upper SRAM address lines. A size strap decides which page bit picks the chip.

Top module: `xcd_card_decode`

## Requirements
- R1: When `ctl_wr` is high at a rising clock edge and `cpu_addr[15:4]` equals 0x1E0, control bit `cpu_addr[3:1]` takes the value of `cpu_addr[0]`. Writes with any other `cpu_addr[15:4]` change no bit, and a write changes only the one bit it indexes.
- R2: Asserting `rst_n` low clears all control bits. Without a matching write, every bit keeps its value.
- R3: `memx_sel_n` is low exactly when `mem_en_n` is low and `cpu_addr[15:13]` is 1, 5, 6 or 7.
- R4: `reg_sel_n` is low exactly when `mem_en_n` is low, `cpu_addr[15:13]` is 2 and control bit 0 is 1.
- R5: `card_sel_n` is low when either `memx_sel_n` or `reg_sel_n` is low. `buf_en_n` and `rdb_en_n` equal `card_sel_n`.
- R6: While `mem_en_n` is high, `memx_sel_n`, `reg_sel_n`, `card_sel_n` and all `sram_cs_n` bits are high.
- R7: `map_mode_n` is low exactly when control bit 1 is 1 and `memx_sel_n` is low.
- R8: `map_oe_n` is high exactly when `reg_sel_n` is low.
- R9: The effective page is `map_pg` while `map_mode_n` is low. Otherwise it is `cpu_addr[15:12]` zero-extended to 8 bits, so 0x2xxx uses page 2 and 0xAxxx uses page 10.
- R10: With `big_chip`=1, the chip index is page bit 5 and `sram_addr[17]` is page bit 7. With `big_chip`=0, the chip index is page bit 7 and `sram_addr[17]` is 1. `sram_cs_n[i]` is low only when `memx_sel_n` is low and the chip index equals i.
- R11: `sram_addr[11:0]` is `cpu_addr[11:0]`, `sram_addr[16:12]` is page bits 4..0, and `sram_addr[18]` is page bit 6.
- R12: `sram_we_n` equals `bus_we_n`, and `sram_oe_n` is the inverse of `bus_dbin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control-bit latch |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address; also carries the control-bus address and data bit |
| mem_en_n | input | 1 | Active-low memory cycle strobe |
| ctl_wr | input | 1 | Control-bus write strobe, sampled on the clock |
| bus_we_n | input | 1 | Active-low bus write strobe |
| bus_dbin | input | 1 | Bus read strobe, active high |
| map_pg | input | 8 | Page number read out of the mapper register file |
| big_chip | input | 1 | Strap: 1 for large SRAM devices, 0 for small |
| memx_sel_n | output | 1 | Expansion RAM window select |
| reg_sel_n | output | 1 | Mapper register window select |
| card_sel_n | output | 1 | Combined card select |
| buf_en_n | output | 1 | Data bus buffer enable |
| rdb_en_n | output | 1 | Read-data buffer enable |
| map_mode_n | output | 1 | Map mode request to the mapper |
| map_oe_n | output | 1 | Mapper page output enable |
| sram_cs_n | output | 2 | Per-chip SRAM selects |
| sram_addr | output | 19 | SRAM address |
| sram_we_n | output | 1 | SRAM write enable |
| sram_oe_n | output | 1 | SRAM output enable |

## Verification
The only state is the control-bit latch. A wrong value there is visible at the ports in the first cycle after the write edge. A stuck bit 0 appears as `reg_sel_n` in the wrong state for every access to 0x4000–0x5FFF. A stuck bit 1 appears as `map_mode_n` in the wrong state, and as the page field of `sram_addr` and the chip selects switching between the bank number and `map_pg`. A write that lands in the wrong bit shows up as soon as the affected window is accessed. Writes to bits 2..7 and to non-matching addresses are therefore judged by re-sweeping the windows and confirming that nothing changes.

// File: rtl/xcd_pkg.sv
package xcd_pkg;
  localparam int ADDR_W   = 16;
  localparam int CTL_N    = 8;
  localparam logic [ADDR_W-1:0] CTL_BASE = 16'h1E00;
  localparam int RGN_W    = 3;
  localparam int BANK_W   = 4;
  localparam int OFFS_W   = 12;
  localparam int PAGE_W   = 8;
  localparam int PG_LOW_W = 5;
  localparam int SRAM_AW  = OFFS_W + PG_LOW_W + 2;
  localparam int CHIPS    = 2;
  localparam logic [(1<<RGN_W)-1:0] MEMX_MASK = 8'b1110_0010;
  localparam int REG_RGN  = 2;
  localparam int BIT_REG_EN   = 0;
  localparam int BIT_MAP_EN   = 1;
  localparam int PG_BIG_SEL   = 5;
  localparam int PG_SMALL_SEL = 7;
  localparam int PG_HI_ADDR   = 7;
  localparam int PG_TOP       = 6;
endpackage

// File: rtl/xcd_ctl_bits.sv
module xcd_ctl_bits
  import xcd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NB = CTL_N,
  parameter logic [AW-1:0] BASE = CTL_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic [NB-1:0] bits
);
  localparam int IDX_W  = $clog2(NB);
  localparam int CMP_LO = IDX_W + 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             val;
  logic [NB-1:0]    bit_en;
  logic [NB-1:0]    bits_q;
  logic [NB-1:0]    bits_d;

  always_comb begin
    hit = wr && (addr[AW-1:CMP_LO] == BASE[AW-1:CMP_LO]);
    idx = addr[IDX_W:1];
    val = addr[0];
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bit
      always_comb begin
        bit_en[b] = hit && (idx == IDX_W'(b));
        bits_d[b] = bit_en[b] ? val : bits_q[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bits_q[b] <= 1'b0;
        end else if (bit_en[b]) begin
          bits_q[b] <= bits_d[b];
        end
      end
    end
  endgenerate

  assign bits = bits_q;

  // R1: a matching write lands its data bit in the indexed position
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (bits[$past(idx)] == $past(val)));

  // R2: with no matching write the whole bit set holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(bits));
endmodule

// File: rtl/xcd_decode.sv
module xcd_decode
  import xcd_pkg::*;
#(
  parameter int RW = RGN_W,
  parameter logic [(1<<RW)-1:0] MEMX = MEMX_MASK,
  parameter int REGR = REG_RGN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rgn,
  input  logic          mem_en_n,
  input  logic          reg_en,
  input  logic          map_en,
  output logic          memx_sel_n,
  output logic          reg_sel_n,
  output logic          card_sel_n,
  output logic          map_mode_n,
  output logic          map_oe_n
);
  localparam int NRGN = 1 << RW;

  logic [NRGN-1:0] rgn_hit;
  logic            memx_act;
  logic            reg_act;

  generate
    for (genvar r = 0; r < NRGN; r++) begin : g_rgn
      assign rgn_hit[r] = !mem_en_n && (rgn == RW'(r));
    end
  endgenerate

  always_comb begin
    memx_act   = |(rgn_hit & MEMX);
    reg_act    = rgn_hit[REGR] && reg_en;
    memx_sel_n = !memx_act;
    reg_sel_n  = !reg_act;
    card_sel_n = !(memx_act || reg_act);
    map_mode_n = !(memx_act && map_en);
    map_oe_n   = reg_act;
  end

  // R6: no strobe while the memory cycle is idle
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_n |-> (memx_sel_n && reg_sel_n && card_sel_n));

  // R3: the two windows never overlap
  assert_windows_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!memx_sel_n, !reg_sel_n}));

  // R4: register window needs control bit 0
  assert_reg_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel_n |-> reg_en);

  // R7: map request only inside the RAM window with bit 1 set
  assert_map_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !map_mode_n |-> (!memx_sel_n && map_en));

  // R8: mapper outputs released during register access
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel_n |-> map_oe_n);
endmodule

// File: rtl/xcd_sram_route.sv
module xcd_sram_route
  import xcd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W,
  parameter int NC = CHIPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               memx_sel_n,
  input  logic               map_mode_n,
  input  logic [PW-1:0]      map_pg,
  input  logic               big_chip,
  input  logic               we_n,
  input  logic               dbin,
  output logic [NC-1:0]      cs_n,
  output logic [SRAM_AW-1:0] s_addr,
  output logic               s_we_n,
  output logic               s_oe_n
);
  localparam int SEL_W = $clog2(NC);

  logic [PW-1:0]    eff_pg;
  logic [SEL_W-1:0] chip_idx;
  logic             hi_bit;

  always_comb begin
    eff_pg   = map_mode_n ? PW'(addr[AW-1 -: BANK_W]) : map_pg;
    chip_idx = big_chip ? SEL_W'(eff_pg[PG_BIG_SEL]) : SEL_W'(eff_pg[PG_SMALL_SEL]);
    hi_bit   = big_chip ? eff_pg[PG_HI_ADDR] : 1'b1;
    s_addr   = {eff_pg[PG_TOP], hi_bit, eff_pg[PG_LOW_W-1:0], addr[OFFS_W-1:0]};
    s_we_n   = we_n;
    s_oe_n   = !dbin;
  end

  generate
    for (genvar c = 0; c < NC; c++) begin : g_chip
      assign cs_n[c] = memx_sel_n || (chip_idx != SEL_W'(c));
    end
  endgenerate

  // R10: no chip selected outside the RAM window
  assert_cs_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memx_sel_n |-> (&cs_n));

  // R10: exactly one chip inside the RAM window
  assert_cs_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !memx_sel_n |-> ($countones(~cs_n) == 1));

  // R10: small devices see the upper address line tied high
  assert_small_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !big_chip |-> s_addr[OFFS_W + PG_LOW_W]);
endmodule

// File: rtl/xcd_card_decode.sv
module xcd_card_decode
  import xcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               mem_en_n,
  input  logic               ctl_wr,
  input  logic               bus_we_n,
  input  logic               bus_dbin,
  input  logic [PAGE_W-1:0]  map_pg,
  input  logic               big_chip,
  output logic               memx_sel_n,
  output logic               reg_sel_n,
  output logic               card_sel_n,
  output logic               buf_en_n,
  output logic               rdb_en_n,
  output logic               map_mode_n,
  output logic               map_oe_n,
  output logic [CHIPS-1:0]   sram_cs_n,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_we_n,
  output logic               sram_oe_n
);
  logic [CTL_N-1:0] ctl_bits;
  logic             ctl_unused;

  assign ctl_unused = ^ctl_bits[CTL_N-1:2];

  xcd_ctl_bits u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .addr  (cpu_addr),
    .bits  (ctl_bits)
  );

  xcd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .rgn        (cpu_addr[ADDR_W-1 -: RGN_W]),
    .mem_en_n   (mem_en_n),
    .reg_en     (ctl_bits[BIT_REG_EN]),
    .map_en     (ctl_bits[BIT_MAP_EN]),
    .memx_sel_n (memx_sel_n),
    .reg_sel_n  (reg_sel_n),
    .card_sel_n (card_sel_n),
    .map_mode_n (map_mode_n),
    .map_oe_n   (map_oe_n)
  );

  assign buf_en_n = card_sel_n;
  assign rdb_en_n = card_sel_n;

  xcd_sram_route u_sram (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (cpu_addr),
    .memx_sel_n (memx_sel_n),
    .map_mode_n (map_mode_n),
    .map_pg     (map_pg),
    .big_chip   (big_chip),
    .we_n       (bus_we_n),
    .dbin       (bus_dbin),
    .cs_n       (sram_cs_n),
    .s_addr     (sram_addr),
    .s_we_n     (sram_we_n),
    .s_oe_n     (sram_oe_n)
  );

  // R5: card select covers both windows
  assert_card_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!memx_sel_n || !reg_sel_n) |-> !card_sel_n);

  // R11: offset lines pass straight through
  assert_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !memx_sel_n |-> (sram_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]));
endmodule

// File: tb/tb_xcd_card_decode.sv
`timescale 1ns/1ps
module tb_xcd_card_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mem_en_n;
  logic        ctl_wr;
  logic        bus_we_n;
  logic        bus_dbin;
  logic [7:0]  map_pg;
  logic        big_chip;
  logic        memx_sel_n, reg_sel_n, card_sel_n, buf_en_n, rdb_en_n;
  logic        map_mode_n, map_oe_n, sram_we_n, sram_oe_n;
  logic [1:0]  sram_cs_n;
  logic [18:0] sram_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic m_b0, m_b1;

  always #10 clk = ~clk;

  xcd_card_decode dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [2:0] idx, input logic v, input logic [11:0] hi);
    @(negedge clk);
    mem_en_n = 1'b1;
    cpu_addr = {hi, idx, v};
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (hi == 12'h1E0) begin
      if (idx == 3'd0) m_b0 = v;
      if (idx == 3'd1) m_b1 = v;
    end
  endtask

  task automatic check_access(input logic [15:0] a, input logic men_n, input logic [7:0] pg,
                              input logic big, input logic we, input logic db);
    logic [2:0] rg;
    logic memx, rgs, mm, sel, a17;
    logic [7:0] page;
    string tg;
    @(negedge clk);
    cpu_addr = a; mem_en_n = men_n; map_pg = pg; big_chip = big;
    bus_we_n = we; bus_dbin = db;
    #2;
    rg   = a[15:13];
    memx = !men_n && (rg == 3'd1 || rg >= 3'd5);
    rgs  = !men_n && (rg == 3'd2) && m_b0;
    mm   = m_b1 && memx;
    page = mm ? pg : {4'h0, a[15:12]};
    sel  = big ? page[5] : page[7];
    a17  = big ? page[7] : 1'b1;
    tg = men_n ? "R6" : "R3";
    chk({tg, " memx_sel_n"}, memx_sel_n, !memx);
    tg = men_n ? "R6" : "R4";
    chk({tg, " reg_sel_n"}, reg_sel_n, !rgs);
    chk("R5 card_sel_n", card_sel_n, !(memx || rgs));
    chk("R5 buffer enables", {buf_en_n, rdb_en_n}, {2{!(memx || rgs)}});
    chk("R7 map_mode_n", map_mode_n, !mm);
    chk("R8 map_oe_n", map_oe_n, rgs);
    chk("R9 page field", sram_addr[16:12], page[4:0]);
    chk("R10 sram_cs_n", sram_cs_n, {!(memx && sel), !(memx && !sel)});
    chk("R10 upper address bit", sram_addr[17], a17);
    chk("R11 sram_addr", sram_addr, {page[6], a17, page[4:0], a[11:0]});
    chk("R12 strobes", {sram_we_n, sram_oe_n}, {we, !db});
  endtask

  task automatic sweep(input logic [7:0] seed);
    for (int big = 0; big < 2; big++)
      for (int bank = 0; bank < 16; bank++)
        for (int men = 0; men < 2; men++)
          check_access({bank[3:0], 12'h5A3 ^ 12'(bank * 17)}, men[0],
                       seed ^ 8'(bank * 29), big[0], bank[0], bank[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0; mem_en_n = 1'b1; ctl_wr = 1'b0;
    bus_we_n = 1'b1; bus_dbin = 1'b0; map_pg = 8'h00; big_chip = 1'b1;
    m_b0 = 1'b0; m_b1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state, both windows in default behaviour
    check_access(16'h4000, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R2 reset reg window closed", reg_sel_n, 1'b1);
    check_access(16'h2000, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R2 reset pass-through", map_mode_n, 1'b1);

    // main sweeps under every bit 0 / bit 1 combination
    for (int b = 0; b < 4; b++) begin
      ctl_write(3'd0, b[0], 12'h1E0);
      ctl_write(3'd1, b[1], 12'h1E0);
      sweep(8'hC3 ^ 8'(b * 77));
    end

    // R1: non-matching base must not touch bit 0 or bit 1
    ctl_write(3'd0, 1'b0, 12'h1E0);
    ctl_write(3'd1, 1'b0, 12'h1E0);
    ctl_write(3'd0, 1'b1, 12'h1E1);
    ctl_write(3'd1, 1'b1, 12'h0E0);
    check_access(16'h4002, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R1 foreign address ignored (bit0)", reg_sel_n, 1'b1);
    check_access(16'hA010, 1'b0, 8'h80, 1'b1, 1'b1, 1'b1);
    chk("R1 foreign address ignored (bit1)", map_mode_n, 1'b1);

    // R1: writes to the other six bits leave behaviour unchanged
    for (int i = 2; i < 8; i++) ctl_write(3'(i), 1'b1, 12'h1E0);
    sweep(8'h5A);

    // R1: single bit set, the neighbour stays clear
    ctl_write(3'd1, 1'b1, 12'h1E0);
    check_access(16'h5FFE, 1'b0, 8'h21, 1'b0, 1'b0, 1'b1);
    chk("R1 bit0 still clear", reg_sel_n, 1'b1);
    check_access(16'hF123, 1'b0, 8'h21, 1'b0, 1'b0, 1'b1);
    chk("R1 bit1 set", map_mode_n, 1'b0);

    // R2: reset in mid-run clears the bits again
    ctl_write(3'd0, 1'b1, 12'h1E0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_b0 = 1'b0; m_b1 = 1'b0;
    check_access(16'h4000, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R2 reset clears bit0", reg_sel_n, 1'b1);
    check_access(16'hB000, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R2 reset clears bit1", map_mode_n, 1'b1);
    sweep(8'h96);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule